// File: doc/BRIEF.md
# Guarded Burst-Sequencing Controller

This block is a clocked four-state controller that follows a fixed cycle of input bursts on three single-bit inputs, `in_a`, `in_b` and `in_c`, and answers each one with a burst on two outputs, `out_x` and `out_y`. In each state it keeps a record of the input edges it has seen since it entered that state. It moves on only when the full burst for one of its enabled transitions has arrived. Two of the transitions are also gated by the level of `in_b`. That level is tested, not waited for as an edge, so a burst that has already arrived stays pending until the guard holds.

The states are called REST, RUN, MARK and PARK. The transitions are:
- REST to RUN on `in_a` rising, which raises `out_y`. `in_b` is free to change in REST.
- RUN to MARK on `in_a` falling with `in_b` high, which raises `out_x` and drops `out_y`.
- RUN to PARK on `in_c` rising with `in_b` high, which drops `out_y`.
- MARK to REST on `in_b` falling, which drops `out_x`.
- PARK to RUN on `in_c` falling, which raises `out_y`.

`in_b` is a free input in RUN and in PARK. The environment must keep to fundamental mode: it starts no new burst until the outputs of the previous one have settled. Any input edge that the current state neither expects nor tolerates sets a sticky `proto_err` flag. Reset clears that flag.

Top module: `burst_seq_ctrl`

## Requirements
- R1: During and after reset the controller is in REST with `out_x`=0, `out_y`=0 and `proto_err`=0.
- R2: In REST, a rising edge on `in_a` moves to RUN and sets `out_y`=1, `out_x`=0. Edges on `in_b` in REST change neither output nor `proto_err`.
- R3: In RUN, a falling edge on `in_a` while `in_b` is high moves to MARK, with `out_x`=1 and `out_y`=0. The two outputs are never both high.
- R4: In RUN, a rising edge on `in_c` while `in_b` is high moves to PARK, with `out_x`=0 and `out_y`=0.
- R5: In RUN, a completed burst whose guard is low leaves the outputs unchanged. When `in_b` later rises, the pending transition fires on the second rising clock edge after the change on `in_b`.
- R6: In RUN, if both the `in_a` fall and the `in_c` rise are pending when the guard holds, the `in_a` transition to MARK is taken.
- R7: In MARK, a falling edge on `in_b` moves to REST with `out_x`=0 and `out_y`=0.
- R8: In PARK, a falling edge on `in_c` moves back to RUN with `out_y`=1.
- R9: The outputs of a transition change on the second rising clock edge after the last burst input changes. They do not change on the first.
- R10: An edge on an input that the current state does not accept sets `proto_err`. The flag stays set until reset. The edge does not change the state. Accepted inputs per state: REST {a,b}, RUN {a,b,c}, MARK {b}, PARK {b,c}.
- R11: Edges on `in_b` in RUN and in PARK change neither output, except by making a pending guarded transition fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Burst input a |
| in_b | input | 1 | Burst input b; also the guard level |
| in_c | input | 1 | Burst input c |
| out_x | output | 1 | Output x |
| out_y | output | 1 | Output y |
| proto_err | output | 1 | Sticky flag for an unexpected input edge |

## Verification
The bench targets the guarded transitions in RUN.

A burst that arrives while the guard is low must stay pending and must not be lost. A design that discarded it would never fire when `in_b` rises. A design that ignored the guard would fire too early.

When both RUN bursts are pending, the bench checks that the `in_a` transition wins. A design with the priorities reversed would settle in PARK with both outputs low instead of reaching MARK.

The bench also checks the exact two-edge latency. This exposes a design that fires straight from the raw edge, without recording it first.

Finally, the bench checks that `in_b` toggles in REST, RUN and PARK are tolerated. A design that counted them as protocol errors would raise `proto_err`, and one that treated them as bursts would move its outputs.

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int NIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_x,
  output logic out_y,
  output logic proto_err
);
  localparam int IA = 0;
  localparam int IB = 1;
  localparam int IC = 2;

  typedef enum logic [3:0] {
    ST_REST = 4'b0001,
    ST_RUN  = 4'b0010,
    ST_MARK = 4'b0100,
    ST_PARK = 4'b1000
  } state_t;

  state_t state, nxt;
  logic [NIN-1:0] in_now, in_q, rise, fall, rise_seen, fall_seen, accept;
  logic nx_x, nx_y;

  assign in_now = {in_c, in_b, in_a};
  assign rise   = in_now & ~in_q;
  assign fall   = ~in_now & in_q;

  always_comb begin
    accept = '0;
    case (state)
      ST_REST: begin accept[IA] = 1'b1; accept[IB] = 1'b1; end
      ST_RUN:  accept = '1;
      ST_MARK: accept[IB] = 1'b1;
      ST_PARK: begin accept[IB] = 1'b1; accept[IC] = 1'b1; end
      default: accept = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_REST: if (rise_seen[IA]) nxt = ST_RUN;
      ST_RUN: begin
        if (in_q[IB] && fall_seen[IA])      nxt = ST_MARK;
        else if (in_q[IB] && rise_seen[IC]) nxt = ST_PARK;
      end
      ST_MARK: if (fall_seen[IB]) nxt = ST_REST;
      ST_PARK: if (fall_seen[IC]) nxt = ST_RUN;
      default: nxt = ST_REST;
    endcase
  end

  assign nx_x = (nxt == ST_MARK);
  assign nx_y = (nxt == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_REST;
      in_q      <= '0;
      rise_seen <= '0;
      fall_seen <= '0;
      out_x     <= 1'b0;
      out_y     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      in_q  <= in_now;
      state <= nxt;
      out_x <= nx_x;
      out_y <= nx_y;
      if (nxt != state) begin
        rise_seen <= '0;
        fall_seen <= '0;
      end else begin
        rise_seen <= rise_seen | rise;
        fall_seen <= fall_seen | fall;
      end
      proto_err <= proto_err | (|((rise | fall) & ~accept));
    end
  end

  assert_outputs_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(out_x && out_y));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_x_rise_guarded_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_x) |-> $past(in_q[IB]));

  assert_y_rise_recorded_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_y) |-> ($past(rise_seen) != '0 || $past(fall_seen) != '0));

  assert_guard_low_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !in_q[IB]) |=> (state == ST_RUN));

endmodule

// File: tb/test_burst_seq_ctrl.sv
`timescale 1ns/1ps
module test_burst_seq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
  logic out_x, out_y, proto_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int m_st;
  bit m_lv[3];
  bit m_rs[3];
  bit m_fs[3];
  bit m_err;

  always #2 clk = ~clk;

  burst_seq_ctrl i_burst_seq_ctrl (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_x(out_x), .out_y(out_y), .proto_err(proto_err)
  );

  function automatic bit ok_in(int st, int ch);
    case (st)
      1: return ch != 2;
      2: return 1'b1;
      3: return ch == 1;
      default: return ch != 0;
    endcase
  endfunction

  function automatic bit exp_x();
    return m_st == 3;
  endfunction

  function automatic bit exp_y();
    return m_st == 2;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin m_rs[i] = 0; m_fs[i] = 0; end
  endtask

  task automatic model_eval();
    int nx;
    nx = m_st;
    case (m_st)
      1: if (m_rs[0]) nx = 2;
      2: if (m_lv[1] && m_fs[0]) nx = 3; else if (m_lv[1] && m_rs[2]) nx = 4;
      3: if (m_fs[1]) nx = 1;
      default: if (m_fs[2]) nx = 2;
    endcase
    if (nx != m_st) begin m_st = nx; model_clear(); end
  endtask

  task automatic drive(int ch, bit v);
    if (m_lv[ch] != v) begin
      if (!ok_in(m_st, ch)) m_err = 1;
      if (v) m_rs[ch] = 1; else m_fs[ch] = 1;
      m_lv[ch] = v;
    end
    case (ch)
      0: in_a = v;
      1: in_b = v;
      default: in_c = v;
    endcase
    model_eval();
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {x,y,err} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    check(tag, {out_x, out_y, proto_err}, {exp_x(), exp_y(), m_err});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_a = 0; in_b = 0; in_c = 0;
    m_st = 1; m_err = 0;
    for (int i = 0; i < 3; i++) m_lv[i] = 0;
    model_clear();
    edges(3);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    check("R1 reset", {out_x, out_y, proto_err}, 3'b000);

    drive(0, 1);
    edges(1);
    check("R9 no change after first edge", {out_x, out_y, proto_err}, 3'b000);
    edges(1);
    check("R2 R9 a rise gives y", {out_x, out_y, proto_err}, 3'b010);

    drive(1, 1); edges(3);
    drive(1, 0); edges(3);
    drive(1, 1); edges(3);
    check("R11 b toggles in RUN", {out_x, out_y, proto_err}, 3'b010);

    drive(0, 0); edges(3);
    check("R3 a fall guarded", {out_x, out_y, proto_err}, 3'b100);

    drive(1, 0); edges(3);
    check("R7 b fall to REST", {out_x, out_y, proto_err}, 3'b000);

    drive(1, 1); edges(3);
    drive(1, 0); edges(3);
    check("R2 b free in REST", {out_x, out_y, proto_err}, 3'b000);

    drive(0, 1); edges(3);
    drive(2, 1); edges(4);
    check("R5 c rise with guard low holds", {out_x, out_y, proto_err}, 3'b010);
    drive(1, 1);
    edges(1);
    check("R5 guard rise first edge", {out_x, out_y, proto_err}, 3'b010);
    edges(1);
    check("R4 R5 fires to PARK", {out_x, out_y, proto_err}, 3'b000);

    drive(1, 0); edges(3);
    drive(1, 1); edges(3);
    check("R11 b toggles in PARK", {out_x, out_y, proto_err}, 3'b000);
    drive(2, 0); edges(3);
    check("R8 c fall back to RUN", {out_x, out_y, proto_err}, 3'b010);

    drive(1, 0); edges(3);
    drive(0, 0); edges(3);
    drive(2, 1); edges(3);
    check("R5 both pending guard low", {out_x, out_y, proto_err}, 3'b010);
    drive(1, 1); edges(3);
    check("R6 a fall wins", {out_x, out_y, proto_err}, 3'b100);
    drive(1, 0); edges(3);
    check("R7 back to REST", {out_x, out_y, proto_err}, 3'b000);

    for (int k = 0; k < 400; k++) begin
      int ch;
      bit v;
      ch = -1; v = 0;
      case (m_st)
        1: if (!m_lv[0] && ($urandom % 2)) begin ch = 0; v = 1; end
           else begin ch = 1; v = !m_lv[1]; end
        2: begin
          int r;
          r = $urandom % 3;
          if (r == 0 && m_lv[0] && !m_fs[0]) begin ch = 0; v = 0; end
          else if (r == 1 && !m_lv[2] && !m_rs[2]) begin ch = 2; v = 1; end
          else begin ch = 1; v = !m_lv[1]; end
        end
        3: begin ch = 1; v = 0; end
        default: if ($urandom % 2) begin ch = 2; v = 0; end
                 else begin ch = 1; v = !m_lv[1]; end
      endcase
      drive(ch, v);
      edges(3);
      check_model("R2 R3 R4 R5 R6 R7 R8 R11 random");
    end

    do_reset();
    check("R1 reset after run", {out_x, out_y, proto_err}, 3'b000);
    drive(2, 1); edges(3);
    check("R10 c edge in REST flags", {out_x, out_y, proto_err}, 3'b001);
    drive(0, 1); edges(3);
    check("R10 sticky state unaffected", {out_x, out_y, proto_err}, 3'b011);
    check_model("R10 model agrees");
    do_reset();
    check("R1 reset clears flag", {out_x, out_y, proto_err}, 3'b000);
    drive(0, 1); edges(3);
    drive(1, 1); edges(3);
    drive(0, 0); edges(3);
    drive(2, 1); edges(3);
    check("R10 c edge in MARK", {out_x, out_y, proto_err}, 3'b101);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule